// File: doc/BRIEF.md
# Gated Timer/Counter with Auto-Reload

This block is one timer/counter channel of a small controller. It keeps a count in two byte registers and steps it on one of two sources. The first source is an internal tick, which is the system clock divided by `PRESC_DIV`. The second source is the falling edges of an external count pin. Counting is allowed only while the run input is high. If the gate enable is set, the synchronized external gate pin must also be high. Software loads the count bytes and the reload bytes through byte-wide write strobes. It acknowledges an overflow through a clear strobe.

Two layouts are available. The 13-bit layout uses all of the high byte and the five low bits of the low byte, and it wraps to zero. The 16-bit layout counts across both bytes. When it passes FFFFh, it takes its next value from the reload bytes. In both layouts a wrap raises the overflow flag, and that flag is the interrupt request of the channel.

Top module: `tmr_chan`

## Requirements
- R1: After reset, both count bytes read 00h, both reload bytes hold 00h, and the overflow flag is 0.
- R2: The count steps only when `run_i` is 1 and either `gate_en_i` is 0 or `ext_gate_i` (after two synchronizer flops) is 1. In every other case the count holds.
- R3: When `ctr_sel_i`=0, the count advances once every `PRESC_DIV` clocks and pin activity is ignored. When `ctr_sel_i`=1, each falling edge of `ext_cnt_i` adds exactly one, and internal ticks are ignored. The new value appears 3 clock edges after the pin falls.
- R4: When `mode_i`=0, the count is {high byte, low byte bits 4:0} (13 bits). It steps 1FFFh to 0000h and sets the overflow flag on that step. Low byte bits 7:5 have no defined value in this layout.
- R5: When `mode_i`=1, the count is {high byte, low byte} (16 bits). On the step from FFFFh, the count is loaded with {reload high, reload low} and the overflow flag is set on the same edge.
- R6: With the reload bytes at their reset value, the 16-bit layout wraps FFFFh to 0000h, which gives a full 65536-step period.
- R7: Raising `run_i` does not change the count. Counting continues from the held value.
- R8: A cycle with `ovf_clr_i`=1 clears the overflow flag. If an overflow occurs in that same cycle, the flag stays at 1.
- R9: A write to either count byte in a cycle that also has a count event discards the event. The written byte takes `wdata_i` and the other byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run control |
| gate_en_i | input | 1 | 1: require external gate pin high to count |
| ctr_sel_i | input | 1 | 0: count internal ticks, 1: count pin falling edges |
| mode_i | input | 1 | 0: 13-bit layout, 1: 16-bit with reload |
| wdata_i | input | 8 | Write data for count and reload bytes |
| cnt_hi_we_i | input | 1 | Write strobe, count high byte |
| cnt_lo_we_i | input | 1 | Write strobe, count low byte |
| rld_hi_we_i | input | 1 | Write strobe, reload high byte |
| rld_lo_we_i | input | 1 | Write strobe, reload low byte |
| ovf_clr_i | input | 1 | Clear overflow flag |
| ext_cnt_i | input | 1 | External count pin, asynchronous |
| ext_gate_i | input | 1 | External gate pin, asynchronous |
| cnt_hi_o | output | 8 | Count high byte |
| cnt_lo_o | output | 8 | Count low byte |
| ovf_o | output | 1 | Overflow flag and interrupt request |

## Verification
Writes and internal-tick steps show on the outputs at the edge that samples them. The bench drives inputs on falling edges and reads outputs one falling edge later. A falling edge on the count pin needs three edges: two synchronizer flops and then the counter register. The bench therefore reads two falling edges after the drive to confirm nothing has changed yet, and a third time to see the step. The gate pin is given four idle cycles to settle before each run window. Each tick-counting window lasts exactly a multiple of `PRESC_DIV` edges, so the expected step count does not depend on the divider's phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned M0_LO_W = 5;
  localparam int unsigned M0_W = BYTE_W + M0_LO_W;
  localparam int unsigned M1_W = 2 * BYTE_W;

  typedef enum logic {
    MODE_13B = 1'b0,
    MODE_16R = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));

      p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= RST_VAL;
      s1_q <= RST_VAL;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end
  assign q_o = s1_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              inc_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic              rh_we_i,
  input  logic              rl_we_i,
  input  logic              ovf_clr_i,
  output logic [BYTE_W-1:0] th_o,
  output logic [BYTE_W-1:0] tl_o,
  output logic              ovf_o
);
  logic [BYTE_W-1:0] th_q, tl_q, rh_q, rl_q, th_n, tl_n;
  logic              ovf_q, step, wrap, ovf_evt;
  logic [M0_W-1:0]   c13, c13_inc;
  logic [M1_W-1:0]   c16;

  assign c13     = {th_q, tl_q[M0_LO_W-1:0]};
  assign c16     = {th_q, tl_q};
  assign c13_inc = c13 + 1'b1;
  // a count-byte write discards the event (R9)
  assign step    = inc_i & ~(hi_we_i | lo_we_i);
  assign wrap    = (mode_i == MODE_16R) ? (&c16) : (&c13);
  assign ovf_evt = step & wrap;

  always_comb begin
    th_n = th_q;
    tl_n = tl_q;
    if (step) begin
      if (mode_i == MODE_16R) begin
        if (wrap) {th_n, tl_n} = {rh_q, rl_q};
        else      {th_n, tl_n} = c16 + 1'b1;
      end else begin
        th_n = c13_inc[M0_W-1:M0_LO_W];
        tl_n = {tl_q[BYTE_W-1:M0_LO_W], c13_inc[M0_LO_W-1:0]};
      end
    end
    if (hi_we_i) th_n = wdata_i;
    if (lo_we_i) tl_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      th_q  <= '0;
      tl_q  <= '0;
      rh_q  <= '0;
      rl_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      th_q <= th_n;
      tl_q <= tl_n;
      if (rh_we_i) rh_q <= wdata_i;
      if (rl_we_i) rl_q <= wdata_i;
      if (ovf_evt)        ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign th_o  = th_q;
  assign tl_o  = tl_q;
  assign ovf_o = ovf_q;

  p_wr_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_we_i |=> (th_o == $past(wdata_i)));
  p_wr_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> (tl_o == $past(wdata_i)));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !hi_we_i && !lo_we_i && mode_i == MODE_16R && th_o == '1 && tl_o == '1)
      |=> ({th_o, tl_o} == $past({rh_q, rl_q}) && ovf_o));
  p_m0_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !hi_we_i && !lo_we_i && mode_i == MODE_13B && th_o == '1
     && tl_o[M0_LO_W-1:0] == '1)
      |=> (th_o == '0 && tl_o[M0_LO_W-1:0] == '0 && ovf_o));
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !inc_i) |=> !ovf_o);
  p_no_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ovf_clr_i) |=> $stable(ovf_o));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              gate_en_i,
  input  logic              ctr_sel_i,
  input  logic              mode_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              cnt_hi_we_i,
  input  logic              cnt_lo_we_i,
  input  logic              rld_hi_we_i,
  input  logic              rld_lo_we_i,
  input  logic              ovf_clr_i,
  input  logic              ext_cnt_i,
  input  logic              ext_gate_i,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic              ovf_o
);
  logic       tick, cnt_s, gate_s, cnt_prev_q, fall, src_evt, allow, inc;
  logic [1:0] pins_s;

  tmr_presc #(.DIV(PRESC_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  // bit0: count pin idles high, bit1: gate pin
  tmr_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_gate_i, ext_cnt_i}),
    .q_o   (pins_s)
  );
  assign cnt_s  = pins_s[0];
  assign gate_s = pins_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_prev_q <= 1'b1;
    else         cnt_prev_q <= cnt_s;
  end
  assign fall    = cnt_prev_q & ~cnt_s;
  assign src_evt = ctr_sel_i ? fall : tick;
  assign allow   = run_i & (~gate_en_i | gate_s);
  assign inc     = allow & src_evt;

  tmr_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (tmr_mode_e'(mode_i)),
    .inc_i    (inc),
    .wdata_i  (wdata_i),
    .hi_we_i  (cnt_hi_we_i),
    .lo_we_i  (cnt_lo_we_i),
    .rh_we_i  (rld_hi_we_i),
    .rl_we_i  (rld_lo_we_i),
    .ovf_clr_i(ovf_clr_i),
    .th_o     (cnt_hi_o),
    .tl_o     (cnt_lo_o),
    .ovf_o    (ovf_o)
  );

  p_gate_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!run_i || (gate_en_i && !gate_s)) && !cnt_hi_we_i && !cnt_lo_we_i)
      |=> ($stable(cnt_hi_o) && $stable(cnt_lo_o)));
  p_fall_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> !fall);
  p_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !gate_en_i && !src_evt && !cnt_hi_we_i && !cnt_lo_we_i)
      |=> ($stable(cnt_hi_o) && $stable(cnt_lo_o)));
endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb_top;
  localparam int unsigned DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       run = 0, gate_en = 0, ctr_sel = 0, mode = 1;
  logic [7:0] wdata = 0;
  logic       hi_we = 0, lo_we = 0, rh_we = 0, rl_we = 0, ovf_clr = 0;
  logic       ext_cnt = 1, ext_gate = 0;
  logic [7:0] cnt_hi, cnt_lo;
  logic       ovf;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  tmr_chan #(.PRESC_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .gate_en_i(gate_en),
    .ctr_sel_i(ctr_sel), .mode_i(mode), .wdata_i(wdata),
    .cnt_hi_we_i(hi_we), .cnt_lo_we_i(lo_we), .rld_hi_we_i(rh_we),
    .rld_lo_we_i(rl_we), .ovf_clr_i(ovf_clr), .ext_cnt_i(ext_cnt),
    .ext_gate_i(ext_gate), .cnt_hi_o(cnt_hi), .cnt_lo_o(cnt_lo), .ovf_o(ovf)
  );

  function automatic logic [15:0] c16();
    return {cnt_hi, cnt_lo};
  endfunction
  function automatic logic [15:0] c13();
    return {3'b0, cnt_hi, cnt_lo[4:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0 count hi, 1 count lo, 2 reload hi, 3 reload lo
  task automatic wr(input int sel, input logic [7:0] v);
    wdata = v;
    hi_we = (sel == 0); lo_we = (sel == 1); rh_we = (sel == 2); rl_we = (sel == 3);
    cyc(1);
    hi_we = 0; lo_we = 0; rh_we = 0; rl_we = 0;
  endtask

  task automatic set16(input logic [15:0] v);
    wr(0, v[15:8]);
    wr(1, v[7:0]);
  endtask

  task automatic clr_flag();
    ovf_clr = 1; cyc(1); ovf_clr = 0;
  endtask

  task automatic pulse();
    ext_cnt = 0; cyc(3);
    ext_cnt = 1; cyc(3);
  endtask

  task automatic run_window(input logic r, input int k);
    run = r; cyc(DIV * k); run = 0;
  endtask

  initial begin
    cyc(2);
    check("R1 hi", {8'h0, cnt_hi}, 16'h0);
    check("R1 lo", {8'h0, cnt_lo}, 16'h0);
    check("R1 ovf", {15'h0, ovf}, 16'h0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 held", c16(), 16'h0);

    // R2/R7: timer mode, gating sweep
    mode = 1; ctr_sel = 0;
    set16(16'h1234);
    cyc(20);
    check("R2 idle hold", c16(), 16'h1234);
    for (int c = 0; c < 8; c++) begin
      logic [15:0] st;
      logic r, ge, g;
      r = c[0]; ge = c[1]; g = c[2];
      gate_en = ge; ext_gate = g;
      cyc(4);
      st = c16();
      run_window(r, 5);
      check("R2 R7 gate sweep", c16(), st + ((r && (!ge || g)) ? 16'd5 : 16'd0));
    end
    gate_en = 0; ext_gate = 0;

    // R3: timer mode ignores pin activity
    set16(16'h0100);
    run = 1;
    for (int i = 0; i < 20; i++) begin
      ext_cnt = i[1];
      cyc(1);
    end
    run = 0; ext_cnt = 1; cyc(3);
    check("R3 tick count, pin ignored", c16(), 16'h0105);

    // R3: counter mode ignores ticks, edge latency
    ctr_sel = 1; run = 1;
    cyc(40);
    check("R3 ticks ignored", c16(), 16'h0105);
    ext_cnt = 0; cyc(2);
    check("R3 no step before 3 edges", c16(), 16'h0105);
    cyc(1);
    check("R3 step on 3rd edge", c16(), 16'h0106);
    ext_cnt = 1; cyc(3);
    for (int i = 0; i < 7; i++) pulse();
    check("R3 edge count", c16(), 16'h010D);

    // R6: default reload
    set16(16'hFFFF);
    clr_flag();
    pulse();
    check("R6 wrap to zero", c16(), 16'h0000);
    check("R6 flag", {15'h0, ovf}, 16'h1);

    // R8: clear alone, then clear vs overflow
    clr_flag();
    check("R8 clear", {15'h0, ovf}, 16'h0);
    set16(16'hFFFF);
    ext_cnt = 0; cyc(2);
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    check("R8 overflow wins", {15'h0, ovf}, 16'h1);
    ext_cnt = 1; cyc(3);
    clr_flag();

    // R5: 16-bit reload sweep
    wr(2, 8'hAB); wr(3, 8'hCD);
    begin
      logic [15:0] e;
      logic ef;
      e = 16'hFFF8; ef = 0;
      set16(e);
      for (int i = 0; i < 16; i++) begin
        if (e == 16'hFFFF) begin e = 16'hABCD; ef = 1; end
        else e = e + 1;
        pulse();
        check("R5 count", c16(), e);
        check("R5 flag", {15'h0, ovf}, {15'h0, ef});
      end
    end
    clr_flag();

    // R9: write beats count event
    set16(16'h0010);
    ext_cnt = 0; cyc(2);
    wdata = 8'h55; lo_we = 1; cyc(1); lo_we = 0;
    check("R9 lo write wins", c16(), 16'h0055);
    ext_cnt = 1; cyc(3);
    check("R9 no late step", c16(), 16'h0055);
    ext_cnt = 0; cyc(2);
    wdata = 8'h3C; hi_we = 1; cyc(1); hi_we = 0;
    check("R9 hi write wins", c16(), 16'h3C55);
    ext_cnt = 1; cyc(3);

    // R4: 13-bit sweep through wrap
    mode = 0;
    begin
      logic [15:0] e;
      logic ef;
      wr(0, 8'hFF); wr(1, 8'hE0);
      clr_flag();
      e = 16'h1FE0; ef = 0;
      for (int i = 0; i < 40; i++) begin
        if (e == 16'h1FFF) begin e = 0; ef = 1; end
        else e = e + 1;
        pulse();
        check("R4 count", c13(), e);
        check("R4 flag", {15'h0, ovf}, {15'h0, ef});
      end
    end
    wr(0, 8'h12); wr(1, 8'h1F);
    pulse();
    check("R4 carry into hi", c13(), 16'h0260);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule